// File: doc/BRIEF.md
# Framed 16-bit Baseband Serial Port

This block is the word-level serial link between a baseband converter and a DSP. Its receive path and its transmit path run at the same time. Each direction moves 16-bit words framed by a one-bit-wide sync pulse, and each direction is double buffered. A new word can therefore be read or loaded while the next one is still shifting, and words can follow each other with no gap.

The receive bit clock is generated by default. It is the master clock divided by three, and the block drives it out. A configuration input turns the pin into an input, so that the DSP can supply the clock, in bursts if it wishes. The transmit side drives its own frame sync, bit clock and data, all derived from the master clock. Its clock either runs only around transfers or runs all the time. When no word is pending, the three transmit lines are either held low or released to high impedance.

The host side is a plain parallel interface. It offers a received word with ready and overrun flags and a read strobe, and a transmit holding register with a load strobe and an empty flag.

Top module: `bb_serial_port`

## Requirements
- R1: After reset, rxClkOe is 1, rxReady and rxOverrun are 0, txEmpty is 1, txOe is 1, and txClkOut, txFsOut and txDataOut are 0.
- R2: With cfgRxClkExt at 0, rxClkOut runs continuously with a period of 3 clk cycles and is high for 1 of them.
- R3: A receive word starts when rxFs is 1 at a falling receive-clock edge. The next 16 falling edges each sample one bit of rxData, most significant bit first.
- R4: A received word reaches rxWord, and rxReady rises, only at the second falling receive-clock edge after its least significant bit. At the first such edge, rxReady is still 0.
- R5: When rxFs is 1 at the falling edge that samples a least significant bit, the next word follows with no gap, and both words are delivered intact.
- R6: rxReady is 1 while an unread word is held. A pulse on rxRead clears both rxReady and rxOverrun. If a word is delivered while rxReady is 1, rxOverrun is set and rxWord takes the newer word. rxOverrun is never 1 while rxReady is 0.
- R7: With cfgRxClkExt at 1, rxClkOe is 0. Bits and sync are then sampled at falling edges of rxClkIn after a two-flop synchronizer, so rxClkIn must stay high and low for at least 3 clk cycles each.
- R8: txLoad writes txWord into the holding register and clears txEmpty in the next cycle. txEmpty returns to 1 when the held word moves to the shifter, at the start of its first data bit.
- R9: A transmit sequence that starts from idle begins with one extra bit-clock period with txFsOut at 0. Then comes one period with txFsOut at 1, and then 16 data periods, most significant bit first. Sync and data change only at rising edges of txClkOut, and the bit clock is clk divided by TX_DIV (default 2).
- R10: If a new word is already held when the least significant bit period starts, txFsOut is 1 during that period and the next word's data follows at once, with no extra period in between.
- R11: With cfgTxClkCont at 0, txClkOut is low whenever no sequence is in progress. With cfgTxClkCont at 1, txClkOut toggles all the time the lines are driven.
- R12: With cfgTxIdleHiZ at 1, txOe is 0 while idle and 1 during a sequence. Whenever txOe is 0, txClkOut, txFsOut and txDataOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRxClkExt | input | 1 | 1: receive clock taken from rxClkIn; 0: generated and driven |
| cfgTxClkCont | input | 1 | 1: transmit clock continuous; 0: burst |
| cfgTxIdleHiZ | input | 1 | 1: release transmit lines when idle; 0: hold them low |
| rxClkIn | input | 1 | External receive bit clock |
| rxClkOut | output | 1 | Generated receive bit clock |
| rxClkOe | output | 1 | Output enable for the receive clock pin |
| rxFs | input | 1 | Receive frame sync |
| rxData | input | 1 | Receive serial data |
| rxWord | output | 16 | Last delivered received word |
| rxReady | output | 1 | Unread received word present |
| rxOverrun | output | 1 | A word was delivered over an unread one |
| rxRead | input | 1 | Host read strobe |
| txWord | input | 16 | Word to transmit |
| txLoad | input | 1 | Host load strobe |
| txEmpty | output | 1 | Transmit holding register free |
| txClkOut | output | 1 | Transmit bit clock |
| txFsOut | output | 1 | Transmit frame sync |
| txDataOut | output | 1 | Transmit serial data |
| txOe | output | 1 | Output enable for the three transmit lines |

## Verification
A bit counter off by one in the receive framer shows up as a shifted or truncated rxWord at the very next delivery. A fault in the delivery stage moves the rise of rxReady by a whole receive-clock period (three master cycles), so it is caught at that first word. A transmit sequencer in the wrong state shows at the ports within one bit period: the extra lead period is missing, a stray sync appears, or the number of falling clock edges per sequence is wrong. A wrong idle decision leaves txOe or the burst clock active after the last bit. Every check samples at a falling bit-clock edge, in the way a far-end receiver would.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LEAD,
    TX_FRAME,
    TX_BITS
  } txState_t;

  typedef struct packed {
    logic rxShift;
    logic rxBit;
    logic rxCapture;
    logic rxCommit;
    logic txLoadShift;
    logic txShift;
    logic txDataEn;
  } bspStrobes_t;

endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import bsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RX_DIV = 3,
  parameter int TX_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgRxClkExt,
  input  logic        cfgTxClkCont,
  input  logic        cfgTxIdleHiZ,
  input  logic        rxClkIn,
  input  logic        rxFs,
  input  logic        rxData,
  input  logic        txHoldFull,
  output bspStrobes_t stb,
  output logic        rxClkOut,
  output logic        txClkOut,
  output logic        txFsOut,
  output logic        txOe
);

  localparam int RX_CW   = $clog2(RX_DIV);
  localparam int TX_CW   = $clog2(TX_DIV);
  localparam int TX_HALF = TX_DIV / 2;
  localparam int IDX_W   = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  // Receive clock generation and external-clock synchronisation
  logic [RX_CW-1:0] rxDivCnt;
  logic [2:0]       clkSync;
  logic [1:0]       fsSync;
  logic [1:0]       dataSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDivCnt <= '0;
      clkSync  <= '0;
      fsSync   <= '0;
      dataSync <= '0;
    end else begin
      rxDivCnt <= (rxDivCnt == RX_CW'(RX_DIV - 1)) ? '0 : rxDivCnt + 1'b1;
      clkSync  <= {clkSync[1:0], rxClkIn};
      fsSync   <= {fsSync[0], rxFs};
      dataSync <= {dataSync[0], rxData};
    end
  end

  logic rxClkGen, fallStb, fsBit, dataBit;
  assign rxClkGen = (rxDivCnt == '0);
  assign rxClkOut = rxClkGen;
  assign fallStb  = cfgRxClkExt ? (clkSync[2] & ~clkSync[1]) : rxClkGen;
  assign fsBit    = cfgRxClkExt ? fsSync[1]   : rxFs;
  assign dataBit  = cfgRxClkExt ? dataSync[1] : rxData;

  // Receive framing
  logic             rxActive;
  logic [IDX_W-1:0] rxBitCnt;
  logic [1:0]       rxPend;
  logic             lastBit;

  assign lastBit = fallStb & rxActive & (rxBitCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxBitCnt <= '0;
      rxPend   <= '0;
    end else if (fallStb) begin
      if (lastBit) rxActive <= 1'b0;
      if (rxActive) rxBitCnt <= rxBitCnt + 1'b1;
      if (fsBit) begin
        rxActive <= 1'b1;
        rxBitCnt <= '0;
      end
      if (lastBit) rxPend <= 2'd2;
      else if (rxPend != 2'd0) rxPend <= rxPend - 2'd1;
    end
  end

  // Transmit bit clock and sequencer
  logic [TX_CW-1:0] txDivCnt;
  logic             txTick;
  txState_t         txState;
  logic [IDX_W-1:0] txIdx;
  logic             txFsReg;

  assign txTick = (txDivCnt == TX_CW'(TX_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txDivCnt <= '0;
    else       txDivCnt <= txTick ? '0 : txDivCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
      txFsReg <= 1'b0;
    end else if (txTick) begin
      case (txState)
        TX_IDLE:  if (txHoldFull) txState <= TX_LEAD;
        TX_LEAD: begin
          txState <= TX_FRAME;
          txFsReg <= 1'b1;
        end
        TX_FRAME: begin
          txState <= TX_BITS;
          txIdx   <= LAST_IDX;
          txFsReg <= 1'b0;
        end
        TX_BITS: begin
          if (txIdx == '0) begin
            if (txFsReg) begin
              txIdx   <= LAST_IDX;
              txFsReg <= 1'b0;
            end else begin
              txState <= TX_IDLE;
            end
          end else begin
            txIdx <= txIdx - 1'b1;
            if (txIdx == IDX_W'(1)) txFsReg <= txHoldFull;
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  logic txBusy, phaseHigh;
  assign txBusy    = (txState != TX_IDLE);
  assign phaseHigh = (txDivCnt < TX_CW'(TX_HALF));
  assign txOe      = ~cfgTxIdleHiZ | txBusy;
  assign txClkOut  = phaseHigh & (cfgTxClkCont | txBusy) & txOe;
  assign txFsOut   = txFsReg;

  always_comb begin
    stb             = '0;
    stb.rxShift     = fallStb & rxActive;
    stb.rxBit       = dataBit;
    stb.rxCapture   = lastBit;
    stb.rxCommit    = fallStb & (rxPend == 2'd1);
    stb.txLoadShift = txTick & ((txState == TX_FRAME) |
                      ((txState == TX_BITS) & (txIdx == '0) & txFsReg));
    stb.txShift     = txTick & (txState == TX_BITS);
    stb.txDataEn    = (txState == TX_BITS);
  end

endmodule

// File: rtl/bsp_datapath.sv
module bsp_datapath
  import bsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bspStrobes_t       stb,
  input  logic              rxRead,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txLoad,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxReady,
  output logic              rxOverrun,
  output logic              txHoldFull,
  output logic              txBit
);

  logic [WORD_W-2:0] rxShiftReg;
  logic [WORD_W-1:0] rxStage;
  logic [WORD_W-1:0] txHold;
  logic [WORD_W-1:0] txShiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxStage    <= '0;
      rxWord     <= '0;
    end else begin
      if (stb.rxShift)   rxShiftReg <= {rxShiftReg[WORD_W-3:0], stb.rxBit};
      if (stb.rxCapture) rxStage    <= {rxShiftReg, stb.rxBit};
      if (stb.rxCommit)  rxWord     <= rxStage;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (stb.rxCommit) begin
      rxReady   <= 1'b1;
      rxOverrun <= (rxReady | rxOverrun) & ~rxRead;
    end else if (rxRead) begin
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= '0;
      txHoldFull <= 1'b0;
      txShiftReg <= '0;
    end else begin
      if (txLoad) begin
        txHold     <= txWord;
        txHoldFull <= 1'b1;
      end else if (stb.txLoadShift) begin
        txHoldFull <= 1'b0;
      end
      if (stb.txLoadShift)  txShiftReg <= txHold;
      else if (stb.txShift) txShiftReg <= {txShiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign txBit = stb.txDataEn & txShiftReg[WORD_W-1];

endmodule

// File: rtl/bb_serial_port.sv
module bb_serial_port
  import bsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RX_DIV = 3,
  parameter int TX_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxClkExt,
  input  logic              cfgTxClkCont,
  input  logic              cfgTxIdleHiZ,
  input  logic              rxClkIn,
  output logic              rxClkOut,
  output logic              rxClkOe,
  input  logic              rxFs,
  input  logic              rxData,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxReady,
  output logic              rxOverrun,
  input  logic              rxRead,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txLoad,
  output logic              txEmpty,
  output logic              txClkOut,
  output logic              txFsOut,
  output logic              txDataOut,
  output logic              txOe
);

  bspStrobes_t stb;
  logic        txHoldFull;
  logic        txBit;

  bsp_ctrl #(.WORD_W(WORD_W), .RX_DIV(RX_DIV), .TX_DIV(TX_DIV)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgRxClkExt (cfgRxClkExt),
    .cfgTxClkCont(cfgTxClkCont),
    .cfgTxIdleHiZ(cfgTxIdleHiZ),
    .rxClkIn     (rxClkIn),
    .rxFs        (rxFs),
    .rxData      (rxData),
    .txHoldFull  (txHoldFull),
    .stb         (stb),
    .rxClkOut    (rxClkOut),
    .txClkOut    (txClkOut),
    .txFsOut     (txFsOut),
    .txOe        (txOe)
  );

  bsp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rxRead    (rxRead),
    .txWord    (txWord),
    .txLoad    (txLoad),
    .rxWord    (rxWord),
    .rxReady   (rxReady),
    .rxOverrun (rxOverrun),
    .txHoldFull(txHoldFull),
    .txBit     (txBit)
  );

  assign rxClkOe   = ~cfgRxClkExt;
  assign txEmpty   = ~txHoldFull;
  assign txDataOut = txBit;

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
  input logic clk,
  input logic rstN,
  input logic rxClkOut,
  input logic rxReady,
  input logic rxOverrun,
  input logic txLoad,
  input logic txEmpty,
  input logic txOe,
  input logic txClkOut,
  input logic txFsOut,
  input logic txDataOut
);

  // R2
  rx_clk_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxClkOut |=> !rxClkOut);

  // R2
  rx_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxClkOut) |=> !rxClkOut);

  // R6
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> rxReady);

  // R8
  tx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txEmpty);

  // R8
  tx_empty_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(txLoad));

  // R9
  fs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txFsOut) || $fell(txFsOut)) |-> $rose(txClkOut));

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> (!txClkOut && !txFsOut && !txDataOut));

endmodule

bind bb_serial_port bsp_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxClkOut (rxClkOut),
  .rxReady  (rxReady),
  .rxOverrun(rxOverrun),
  .txLoad   (txLoad),
  .txEmpty  (txEmpty),
  .txOe     (txOe),
  .txClkOut (txClkOut),
  .txFsOut  (txFsOut),
  .txDataOut(txDataOut)
);

// File: tb/tb_bb_serial_port.sv
`timescale 1ns/1ps
module tb_bb_serial_port;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRxClkExt = 1'b0, cfgTxClkCont = 1'b0, cfgTxIdleHiZ = 1'b0;
  logic rxClkIn = 1'b0, rxFs = 1'b0, rxData = 1'b0, rxRead = 1'b0;
  logic [15:0] txWord = '0;
  logic txLoad = 1'b0;
  logic rxClkOut, rxClkOe, rxReady, rxOverrun, txEmpty;
  logic txClkOut, txFsOut, txDataOut, txOe;
  logic [15:0] rxWord;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  bb_serial_port dut (
    .clk(clk), .rstN(rstN), .cfgRxClkExt(cfgRxClkExt),
    .cfgTxClkCont(cfgTxClkCont), .cfgTxIdleHiZ(cfgTxIdleHiZ),
    .rxClkIn(rxClkIn), .rxClkOut(rxClkOut), .rxClkOe(rxClkOe),
    .rxFs(rxFs), .rxData(rxData), .rxWord(rxWord), .rxReady(rxReady),
    .rxOverrun(rxOverrun), .rxRead(rxRead), .txWord(txWord),
    .txLoad(txLoad), .txEmpty(txEmpty), .txClkOut(txClkOut),
    .txFsOut(txFsOut), .txDataOut(txDataOut), .txOe(txOe)
  );

  // Far-end receiver model: records sync and data at each falling tx clock edge
  logic prevTxClk = 1'b0;
  logic fsLog [0:63];
  logic dataLog [0:63];
  int nFall = 0;

  always @(negedge clk) begin
    if (prevTxClk && !txClkOut) begin
      if (nFall < 64) begin
        fsLog[nFall]   = txFsOut;
        dataLog[nFall] = txDataOut;
      end
      nFall = nFall + 1;
    end
    prevTxClk = txClkOut;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rxSlot(input logic fs, input logic d);
    @(posedge rxClkOut);
    #1;
    rxFs = fs;
    rxData = d;
  endtask

  task automatic rxSendWord(input logic [15:0] w, input logic fsLast);
    for (int i = 15; i >= 0; i--) rxSlot((i == 0) ? fsLast : 1'b0, w[i]);
  endtask

  task automatic doRead();
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic txLoadWord(input logic [15:0] w);
    @(negedge clk); txWord = w; txLoad = 1'b1;
    @(negedge clk); txLoad = 1'b0;
  endtask

  task automatic clearLog();
    @(posedge clk); #1; nFall = 0;
  endtask

  task automatic testReset();
    waitClk(4);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rxClkOe", rxClkOe, 1);
    check("R1 rxReady", rxReady, 0);
    check("R1 rxOverrun", rxOverrun, 0);
    check("R1 txEmpty", txEmpty, 1);
    check("R1 txOe", txOe, 1);
    check("R1 tx lines", {txClkOut, txFsOut, txDataOut}, 0);
  endtask

  task automatic testRxClock();
    int highs = 0;
    int doubles = 0;
    logic prev = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rxClkOut) highs++;
      if (rxClkOut && prev) doubles++;
      prev = rxClkOut;
    end
    check("R2 rx clock high cycles in 30", highs, 10);
    check("R2 rx clock never high twice", doubles, 0);
  endtask

  task automatic testRxSingle();
    rxSlot(1'b1, 1'b0);
    rxSendWord(16'hB6C1, 1'b0);
    rxSlot(1'b0, 1'b0);
    rxSlot(1'b0, 1'b0);
    check("R4 not ready at first fall after LSB", rxReady, 0);
    rxSlot(1'b0, 1'b0);
    check("R4 ready at second fall after LSB", rxReady, 1);
    check("R3 received word MSB first", rxWord, 16'hB6C1);
    doRead();
    check("R6 read clears ready", rxReady, 0);
  endtask

  task automatic testRxBackToBack();
    logic [15:0] wordA = 16'h8001;
    logic [15:0] wordB = 16'h3CA5;
    rxSlot(1'b1, 1'b0);
    rxSendWord(wordA, 1'b1);
    for (int i = 15; i >= 0; i--) begin
      rxSlot(1'b0, wordB[i]);
      if (i == 12) begin
        check("R5 first of pair delivered", rxWord, wordA);
        doRead();
      end
    end
    rxSlot(1'b0, 1'b0);
    rxSlot(1'b0, 1'b0);
    rxSlot(1'b0, 1'b0);
    check("R5 second of pair delivered", rxWord, wordB);
    check("R6 no overrun when read in time", rxOverrun, 0);
    doRead();
  endtask

  task automatic testRxOverrun();
    rxSlot(1'b1, 1'b0);
    rxSendWord(16'h1111, 1'b0);
    for (int i = 0; i < 3; i++) rxSlot(1'b0, 1'b0);
    check("R6 ready after first", rxReady, 1);
    check("R6 no overrun yet", rxOverrun, 0);
    rxSlot(1'b1, 1'b0);
    rxSendWord(16'hE00E, 1'b0);
    for (int i = 0; i < 3; i++) rxSlot(1'b0, 1'b0);
    check("R6 overrun set", rxOverrun, 1);
    check("R6 newer word kept", rxWord, 16'hE00E);
    doRead();
    check("R6 read clears overrun", {rxReady, rxOverrun}, 0);
  endtask

  task automatic extSlot(input logic fs, input logic d);
    @(negedge clk);
    rxClkIn = 1'b1; rxFs = fs; rxData = d;
    waitClk(4);
    rxClkIn = 1'b0;
    waitClk(4);
  endtask

  task automatic testRxExternal();
    logic [15:0] w = 16'h5AF0;
    cfgRxClkExt = 1'b1;
    waitClk(2);
    check("R7 clock pin released", rxClkOe, 0);
    extSlot(1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) extSlot(1'b0, w[i]);
    extSlot(1'b0, 1'b0);
    check("R7 not ready after one extra edge", rxReady, 0);
    extSlot(1'b0, 1'b0);
    extSlot(1'b0, 1'b0);
    check("R7 external clock ready", rxReady, 1);
    check("R7 external clock word", rxWord, w);
    doRead();
    cfgRxClkExt = 1'b0;
  endtask

  task automatic checkTxWord(input string what, input int base, input logic [15:0] w);
    int bad = 0;
    for (int k = 0; k < 16; k++) if (dataLog[base + k] !== w[15 - k]) bad++;
    check(what, bad, 0);
  endtask

  task automatic testTxBurst();
    clearLog();
    waitClk(20);
    check("R11 burst clock quiet when idle", nFall, 0);
    txLoadWord(16'hA53C);
    check("R8 load clears empty", txEmpty, 0);
    waitClk(60);
    check("R9 falling edges per sequence", nFall, 18);
    check("R9 lead period sync low", {fsLog[0], dataLog[0]}, 0);
    check("R9 sync period", fsLog[1], 1);
    checkTxWord("R9 data MSB first", 2, 16'hA53C);
    check("R10 no sync on last bit when nothing held", fsLog[17], 0);
    check("R8 empty after move to shifter", txEmpty, 1);
    check("R11 idle low lines", {txClkOut, txFsOut, txDataOut, txOe}, 4'b0001);
  endtask

  task automatic testTxBackToBack();
    int guard = 0;
    clearLog();
    txLoadWord(16'hF00D);
    while (!txEmpty && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    txLoadWord(16'h4B21);
    waitClk(100);
    check("R10 falling edges for pair", nFall, 34);
    check("R10 sync on last bit of first", fsLog[17], 1);
    checkTxWord("R10 first word", 2, 16'hF00D);
    checkTxWord("R10 second word without gap", 18, 16'h4B21);
  endtask

  task automatic testTxContinuous();
    cfgTxClkCont = 1'b1;
    waitClk(4);
    clearLog();
    waitClk(40);
    check("R11 continuous clock edges", nFall, 20);
    check("R11 sync low while idle", txFsOut, 0);
    cfgTxClkCont = 1'b0;
    waitClk(4);
  endtask

  task automatic testTxHiZ();
    cfgTxIdleHiZ = 1'b1;
    waitClk(2);
    check("R12 released when idle", txOe, 0);
    check("R12 lines low when released", {txClkOut, txFsOut, txDataOut}, 0);
    clearLog();
    txLoadWord(16'h0FF0);
    waitClk(6);
    check("R12 driven during sequence", txOe, 1);
    waitClk(60);
    check("R12 released again", txOe, 0);
    check("R12 full sequence sent", nFall, 18);
    checkTxWord("R12 data while driven", 2, 16'h0FF0);
    cfgTxIdleHiZ = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testRxClock();
    testRxSingle();
    testRxBackToBack();
    testRxOverrun();
    testRxExternal();
    testTxBurst();
    testTxBackToBack();
    testTxContinuous();
    testTxHiZ();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule